// File: doc/BRIEF.md
# ADPCM Serial Nibble Port

This block carries 4-bit ADPCM codewords between a codec core and an external serial line. The serial line is timed by its own data clock, which is unrelated to the core clock. The receive half waits for its frame strobe and then shifts one nibble in from the serial input. The transmit half is started by a separate frame strobe and shifts a nibble from the core onto a serial output that is only enabled while it carries bits. Because the two halves are framed on their own, a base station can give each direction a different slot on a shared line.

Toward the core, each finished receive nibble appears as a one-cycle valid strobe with its data. Each accepted transmit frame is reported by a one-cycle strobe, and the core then loads the next word. Both strobes come from toggle flags that pass through a synchroniser chain. The transmit word sits in a core-side holding register. The serial side copies it only at the moment a transmit frame starts. The core updates that register through a write strobe.

The block sits next to the codec core, close to the pads. The tx_oe output sets the pad direction, so the line floats between frames. The data clock may run anywhere from about 1/54 of the master clock up to the master clock rate. For the strobes to cross correctly, the core clock must still be fast enough to see every toggle.

Top module: `adpcm_nib_port`

## Requirements
- R1: When rx_sync is high at a rising dclk edge while the receiver is idle, the next 4 falling dclk edges each capture one bit of rx_sd. The first bit captured becomes rx_data[3] (MSB first) and the fourth becomes rx_data[0].
- R2: After the fourth capture, rx_valid pulses high for exactly one clk cycle with the nibble on rx_data, within SYNC_STAGES+3 clk cycles.
- R3: A high rx_sync at a rising dclk edge while a capture is in progress has no effect: it adds no rx_valid pulse and does not alter the nibble.
- R4: When tx_sync is high at a rising dclk edge while the transmitter is idle, tx_oe is high after each of the next 4 rising dclk edges. tx_sd carries bits 3, 2, 1, 0 of the latched nibble in that order.
- R5: Outside those 4 bit slots tx_oe is low and tx_sd is 0. tx_oe is never high for more than 4 consecutive dclk cycles.
- R6: The transmitted nibble is the value held by the core register at the rising edge where the frame starts. A tx_wr after that edge does not change the word being shifted out.
- R7: A high tx_sync on any of the 4 edges that drive bit slots is ignored. The earliest next start is the rising edge right after the last bit slot.
- R8: Every transmit frame start produces exactly one one-cycle tx_taken pulse in the clk domain.
- R9: While rst_n is low, tx_oe, tx_sd, rx_valid, tx_taken and rx_data are all 0.
- R10: Receive and transmit framing run independently: both directions may be active in overlapping dclk cycles without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| tx_data | input | W | Next transmit nibble from the core |
| tx_wr | input | 1 | Loads tx_data into the holding register |
| tx_taken | output | 1 | One-cycle strobe: a transmit frame has latched the held word |
| rx_data | output | W | Last received nibble |
| rx_valid | output | 1 | One-cycle strobe: rx_data holds a new nibble |
| dclk | input | 1 | Serial data clock |
| rx_sync | input | 1 | Receive frame strobe, sampled on rising dclk |
| rx_sd | input | 1 | Receive serial data, captured on falling dclk |
| tx_sync | input | 1 | Transmit frame strobe, sampled on rising dclk |
| tx_sd | output | 1 | Transmit serial data, launched on rising dclk |
| tx_oe | output | 1 | Output enable for the tx_sd pad driver |

## Verification
The hardest situation to reach from the ports is a frame strobe that lands inside a transfer in progress, above all on the last bit slot, where a wrong count would start a second frame or cut the current one short. Directed sequences hold each strobe high across a whole frame and past its end, so that every in-frame slot sees a strobe and back-to-back frames happen. A long constrained-random run then sets both strobes about one cycle in five and writes the core register at random times, including during shifting. A bench model of the framing rules predicts every bit slot and every strobe count.

// File: rtl/nibport_pkg.sv
package nibport_pkg;

   // Default codeword width and synchroniser depth.
   localparam int unsigned NIB_W_DEF  = 4;
   localparam int unsigned SYNC_N_DEF = 2;

   // Transmit shifter phase.
   typedef enum logic {
      TX_IDLE  = 1'b0,
      TX_SHIFT = 1'b1
   } tx_phase_e;

endpackage

// File: rtl/nibport_rx.sv
module nibport_rx #(
   parameter int unsigned W = nibport_pkg::NIB_W_DEF
) (
   input  logic         dclk,
   input  logic         rst_n,
   input  logic         sync_i,
   input  logic         sd_i,
   output logic [W-1:0] word_o,
   output logic         done_tgl_o
);
   localparam int unsigned CW = $clog2(W + 1);

   logic          sync_q;
   logic [CW-1:0] cnt;
   logic [W-1:0]  sh;
   logic [W-1:0]  nxt;

   // Frame strobe is sampled on the rising edge.
   always_ff @(posedge dclk or negedge rst_n) begin
      if (!rst_n) sync_q <= 1'b0;
      else        sync_q <= sync_i;
   end

   assign nxt = {sh[W-2:0], sd_i};

   // Bits are captured on falling edges; a strobe only counts while idle.
   always_ff @(negedge dclk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         sh         <= '0;
         word_o     <= '0;
         done_tgl_o <= 1'b0;
      end else if (cnt != '0 || sync_q) begin
         sh <= nxt;
         if (cnt == CW'(W - 1)) begin
            cnt        <= '0;
            word_o     <= nxt;
            done_tgl_o <= ~done_tgl_o;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/nibport_tx.sv
module nibport_tx
   import nibport_pkg::*;
#(
   parameter int unsigned W = NIB_W_DEF
) (
   input  logic         dclk,
   input  logic         rst_n,
   input  logic         sync_i,
   input  logic [W-1:0] word_i,
   output logic         sd_o,
   output logic         oe_o,
   output logic         start_tgl_o
);
   localparam int unsigned CW = $clog2(W + 1);

   tx_phase_e     phase;
   logic [CW-1:0] cnt;
   logic [W-1:0]  sh;

   always_ff @(posedge dclk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= TX_IDLE;
         cnt         <= '0;
         sh          <= '0;
         sd_o        <= 1'b0;
         oe_o        <= 1'b0;
         start_tgl_o <= 1'b0;
      end else if (phase == TX_IDLE) begin
         oe_o <= 1'b0;
         sd_o <= 1'b0;
         if (sync_i) begin
            sh          <= word_i;
            cnt         <= '0;
            phase       <= TX_SHIFT;
            start_tgl_o <= ~start_tgl_o;
         end
      end else begin
         oe_o <= 1'b1;
         sd_o <= sh[W-1];
         sh   <= {sh[W-2:0], 1'b0};
         if (cnt == CW'(W - 1)) begin
            cnt   <= '0;
            phase <= TX_IDLE;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/nibport_sync.sv
module nibport_sync #(
   parameter int unsigned STAGES = nibport_pkg::SYNC_N_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_i,
   output logic pulse_o
);
   // STAGES synchroniser flops plus one history flop for edge detection.
   logic [STAGES:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ff      <= '0;
         pulse_o <= 1'b0;
      end else begin
         ff      <= {ff[STAGES-1:0], tgl_i};
         pulse_o <= ff[STAGES] ^ ff[STAGES-1];
      end
   end

endmodule

// File: rtl/adpcm_nib_port.sv
module adpcm_nib_port
   import nibport_pkg::*;
#(
   parameter int unsigned W           = NIB_W_DEF,
   parameter int unsigned SYNC_STAGES = SYNC_N_DEF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] tx_data,
   input  logic         tx_wr,
   output logic         tx_taken,
   output logic [W-1:0] rx_data,
   output logic         rx_valid,
   input  logic         dclk,
   input  logic         rx_sync,
   input  logic         rx_sd,
   input  logic         tx_sync,
   output logic         tx_sd,
   output logic         tx_oe
);
   // Elaboration-time parameter checks.
   if (W < 2) begin : g_w_bad
      $error("adpcm_nib_port: W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_sync_bad
      $error("adpcm_nib_port: SYNC_STAGES must be at least 2");
   end

   logic [W-1:0] tx_hold;
   logic [W-1:0] rx_word;
   logic         rx_tgl;
   logic         tx_tgl;
   logic         rx_pulse;

   // Core-side holding register for the next transmit word.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tx_hold <= '0;
      else if (tx_wr) tx_hold <= tx_data;
   end

   nibport_rx #(.W(W)) u_rx (
      .dclk       (dclk),
      .rst_n      (rst_n),
      .sync_i     (rx_sync),
      .sd_i       (rx_sd),
      .word_o     (rx_word),
      .done_tgl_o (rx_tgl)
   );

   nibport_tx #(.W(W)) u_tx (
      .dclk        (dclk),
      .rst_n       (rst_n),
      .sync_i      (tx_sync),
      .word_i      (tx_hold),
      .sd_o        (tx_sd),
      .oe_o        (tx_oe),
      .start_tgl_o (tx_tgl)
   );

   nibport_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .tgl_i   (rx_tgl),
      .pulse_o (rx_pulse)
   );

   nibport_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .tgl_i   (tx_tgl),
      .pulse_o (tx_taken)
   );

   // rx_word has been stable for SYNC_STAGES clk cycles when the pulse arrives.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid <= 1'b0;
         rx_data  <= '0;
      end else begin
         rx_valid <= rx_pulse;
         if (rx_pulse) rx_data <= rx_word;
      end
   end

endmodule

// File: rtl/adpcm_nib_port_chk.sv
module adpcm_nib_port_chk #(
   parameter int unsigned W = 4
) (
   input logic clk,
   input logic rst_n,
   input logic dclk,
   input logic tx_sync,
   input logic tx_oe,
   input logic rx_valid,
   input logic tx_taken
);
   localparam int unsigned RW = $clog2(W + 2);

   // Consecutive dclk cycles with the output enabled, saturating.
   logic [RW-1:0] oe_run;

   always_ff @(posedge dclk or negedge rst_n) begin
      if (!rst_n)                  oe_run <= '0;
      else if (!tx_oe)             oe_run <= '0;
      else if (oe_run != RW'(W+1)) oe_run <= oe_run + 1'b1;
   end

   // R5
   oe_run_chk: assert property (@(posedge dclk) disable iff (!rst_n)
      tx_oe |-> (oe_run < RW'(W)));

   // R4
   oe_start_chk: assert property (@(posedge dclk) disable iff (!rst_n)
      $rose(tx_oe) |-> $past(tx_sync, 2));

   // R2
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R8
   taken_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_taken |=> !tx_taken);

endmodule

bind adpcm_nib_port adpcm_nib_port_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dclk     (dclk),
   .tx_sync  (tx_sync),
   .tx_oe    (tx_oe),
   .rx_valid (rx_valid),
   .tx_taken (tx_taken)
);

// File: tb/tb_adpcm_nib_port.sv
module tb_adpcm_nib_port;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] tx_data = '0;
   logic         tx_wr = 1'b0;
   logic         tx_taken;
   logic [W-1:0] rx_data;
   logic         rx_valid;
   logic         dclk = 1'b0;
   logic         rx_sync = 1'b0;
   logic         rx_sd = 1'b0;
   logic         tx_sync = 1'b0;
   logic         tx_sd;
   logic         tx_oe;

   adpcm_nib_port #(.W(W), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_wr(tx_wr),
      .tx_taken(tx_taken), .rx_data(rx_data), .rx_valid(rx_valid),
      .dclk(dclk), .rx_sync(rx_sync), .rx_sd(rx_sd), .tx_sync(tx_sync),
      .tx_sd(tx_sd), .tx_oe(tx_oe)
   );

   always #4 clk = ~clk;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string ctx = "R9";

   // Port observations in the core domain.
   int         seen_rx = 0;
   logic [3:0] seen_rx_data = '0;
   int         seen_taken = 0;

   always @(negedge clk) begin
      if (rx_valid) begin
         seen_rx++;
         seen_rx_data = rx_data;
      end
      if (tx_taken) seen_taken++;
   end

   // Bench model state.
   logic [3:0] cur_hold = '0;
   bit         m_tx_busy = 1'b0;
   int         m_tx_cnt = 0;
   logic [3:0] m_tx_sh = '0;
   bit         exp_oe = 1'b0;
   bit         exp_sd = 1'b0;
   bit         m_rx_syncq = 1'b0;
   int         m_rx_cnt = 0;
   logic [3:0] m_rx_sh = '0;
   int         exp_rx = 0;
   logic [3:0] exp_rx_data = '0;
   int         exp_taken = 0;
   int         rx_due = 0;
   int         tx_due = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s [%s]: actual %0d expected %0d", tag, ctx, act, expv);
      end
   endtask

   function automatic logic [3:0] shift_in(input logic [3:0] s, input bit b);
      return {s[2:0], b};
   endfunction

   // One dclk period of 52 ns: strobes and write, rising, sample, data, falling.
   task automatic dcycle(input bit rs, input bit ts, input bit rd,
                         input bit wr, input logic [3:0] wdata);
      rx_sync = rs;
      tx_sync = ts;
      if (wr) begin
         tx_data  = wdata;
         tx_wr    = 1'b1;
         cur_hold = wdata;
      end
      #8 tx_wr = 1'b0;
      #5 dclk = 1'b1;
      // transmit model at the rising edge (R4, R6, R7)
      if (!m_tx_busy) begin
         exp_oe = 1'b0;
         exp_sd = 1'b0;
         if (ts) begin
            m_tx_sh   = cur_hold;
            m_tx_busy = 1'b1;
            m_tx_cnt  = 0;
            exp_taken++;
            tx_due = 2;
         end
      end else begin
         exp_oe  = 1'b1;
         exp_sd  = m_tx_sh[3];
         m_tx_sh = {m_tx_sh[2:0], 1'b0};
         m_tx_cnt++;
         if (m_tx_cnt == W) m_tx_busy = 1'b0;
      end
      m_rx_syncq = rs;
      #13;
      if (exp_oe) begin
         chk(tx_oe == 1'b1, "R4 tx_oe in slot", int'(tx_oe), 1);
         chk(tx_sd == exp_sd, "R4 tx_sd bit", int'(tx_sd), int'(exp_sd));
      end else begin
         chk(tx_oe == 1'b0, "R5 tx_oe idle", int'(tx_oe), 0);
         chk(tx_sd == 1'b0, "R5 tx_sd idle", int'(tx_sd), 0);
      end
      if (rx_due > 0) begin
         rx_due--;
         if (rx_due == 0) begin
            chk(seen_rx == exp_rx, "R2 rx_valid count", seen_rx, exp_rx);
            chk(seen_rx_data == exp_rx_data, "R1 rx_data", int'(seen_rx_data),
                int'(exp_rx_data));
         end
      end
      if (tx_due > 0) begin
         tx_due--;
         if (tx_due == 0)
            chk(seen_taken == exp_taken, "R8 tx_taken count", seen_taken, exp_taken);
      end
      rx_sd = rd;
      #13 dclk = 1'b0;
      // receive model at the falling edge (R1, R3)
      if (m_rx_cnt != 0 || m_rx_syncq) begin
         m_rx_sh = shift_in(m_rx_sh, rd);
         m_rx_cnt++;
         if (m_rx_cnt == W) begin
            m_rx_cnt    = 0;
            exp_rx++;
            exp_rx_data = m_rx_sh;
            rx_due      = 3;
         end
      end
      #13;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) dcycle(1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
   endtask

   initial begin : watchdog
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0 (run hung)");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h0005_EED1));
      #50;
      // R9 reset values
      chk(tx_oe == 1'b0, "R9 tx_oe", int'(tx_oe), 0);
      chk(tx_sd == 1'b0, "R9 tx_sd", int'(tx_sd), 0);
      chk(rx_valid == 1'b0, "R9 rx_valid", int'(rx_valid), 0);
      chk(tx_taken == 1'b0, "R9 tx_taken", int'(tx_taken), 0);
      chk(rx_data == 4'h0, "R9 rx_data", int'(rx_data), 0);
      #50 rst_n = 1'b1;
      #1;
      idle(2);

      // R1: one receive frame carrying 1011
      ctx = "R1";
      dcycle(1'b1, 1'b0, 1'b1, 1'b0, 4'h0);
      dcycle(1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
      dcycle(1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
      dcycle(1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
      idle(4);
      chk(seen_rx_data == 4'b1011, "R1 directed nibble", int'(seen_rx_data), 11);

      // R3: strobe held high through the whole capture gives one word
      ctx = "R3";
      dcycle(1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
      dcycle(1'b1, 1'b0, 1'b1, 1'b0, 4'h0);
      dcycle(1'b1, 1'b0, 1'b1, 1'b0, 4'h0);
      dcycle(1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
      idle(5);
      chk(seen_rx == 2, "R3 single word per frame", seen_rx, 2);
      chk(seen_rx_data == 4'b0110, "R3 word intact", int'(seen_rx_data), 6);

      // R6: word latched at the start, a mid-frame write is not sent
      ctx = "R6";
      dcycle(1'b0, 1'b0, 1'b0, 1'b1, 4'b0110);
      dcycle(1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
      dcycle(1'b0, 1'b0, 1'b0, 1'b1, 4'b1001);
      idle(6);

      // R7: strobe held for 7 edges starts frames at edge 0 and edge 5 only
      ctx = "R7";
      dcycle(1'b0, 1'b0, 1'b0, 1'b1, 4'b1101);
      for (int i = 0; i < 7; i++) dcycle(1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
      idle(6);
      chk(seen_taken == 3, "R7 frame starts", seen_taken, 3);

      // R10: both directions started on the same edge
      ctx = "R10";
      dcycle(1'b1, 1'b1, 1'b0, 1'b1, 4'b1010);
      dcycle(1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
      dcycle(1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
      dcycle(1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
      idle(6);

      // R10 random mix of strobes, data and writes
      ctx = "R10 random";
      for (int i = 0; i < 1500; i++) begin
         dcycle(($urandom % 5) == 0, ($urandom % 5) == 0, 1'($urandom),
                ($urandom % 4) == 0, 4'($urandom));
      end
      idle(8);
      chk(seen_rx == exp_rx, "R2 final receive count", seen_rx, exp_rx);
      chk(seen_taken == exp_taken, "R8 final start count", seen_taken, exp_taken);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule